// File: doc/BRIEF.md
# Prioritized Outbound Window Decoder

This block decides whether an internal-bus address belongs to the outbound bus space. It holds three programmable windows. Each window has an enable bit, an 8-bit base, an 8-bit mask and an 8-bit translation value, and all three apply only to address bits 31:24. A window therefore covers 16 MB when its mask is zero. Every mask bit set to one doubles that size, because the bit becomes a don't-care.

For each request, the decoder reports whether any window hit, which window won, and the outgoing address. In the outgoing address, the upper byte is rebuilt from the translation value in the bits the mask fixes. Address bits the mask frees pass through unchanged. Windows may overlap, and the lowest-numbered matching window wins.

Requests arrive on a valid/ready stream, and results leave on another. Both streams use the usual rule: a beat transfers on a clock edge where valid and ready are both high. One register stage sits between them. The input is ready whenever that stage is empty or its result is being taken in the same cycle. If the consumer holds its ready low, the result stays frozen and new requests are refused until it is taken. Windows are programmed through a plain write port.

Top module: `owd_decoder`

## Requirements
- R1: After reset, no result is pending (`out_valid` low, `in_ready` high) and every window is disabled, so the first request misses.
- R2: A window matches when it is enabled and `(addr[31:24] & ~mask) == (base & ~mask)`. A mask bit of 1 marks that address bit as don't-care.
- R3: A disabled window never matches, whatever its base and mask hold.
- R4: When several windows match, the lowest index wins (0 over 1 over 2), and `out_idx` reports that index (0, 1 or 2).
- R5: On a hit, `out_addr` is `{(trans & ~mask) | (addr[31:24] & mask), addr[23:0]}` of the winning window.
- R6: On a miss, `out_hit` is 0, `out_idx` is 0 and `out_addr` equals the request address.
- R7: A request accepted on a clock edge (`in_valid` and `in_ready` high) appears on the output, with `out_valid` high, right after that edge.
- R8: While `out_valid` is high and `out_ready` is low, the result holds steady and `in_ready` is low.
- R9: A window write takes effect for requests accepted on later edges. A request accepted on the same edge as the write is decoded with the previous settings.
- R10: A write whose window index is 3 (no such window) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_win | input | 2 | Window index to write |
| cfg_en | input | 1 | Enable value written |
| cfg_base | input | 8 | Base value for bits 31:24 |
| cfg_mask | input | 8 | Mask value (1 = don't care) |
| cfg_trans | input | 8 | Translation value for the upper byte |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | 32 | Request address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | Some window matched |
| out_idx | output | 2 | Winning window, 0 on a miss |
| out_addr | output | 32 | Translated or passed-through address |

## Verification
The window register file and the one-entry result stage are the only state. A corrupt window entry shows up as a wrong hit flag, index or upper byte on the first request that touches that window's address range. That fault appears one cycle after the request is accepted, not earlier. A faulty result-stage valid bit or hold logic shows up within a cycle, as a dropped, duplicated or changed result, or as `in_ready` disagreeing with the stall state. The bench mirrors all of this with a behavioural model and compares every port on every cycle.

// File: rtl/owd_pkg.sv
package owd_pkg;
  localparam int DEC_W = 8;

  typedef struct packed {
    logic             en;
    logic [DEC_W-1:0] base;
    logic [DEC_W-1:0] mask;
    logic [DEC_W-1:0] trans;
  } win_cfg_t;
endpackage

// File: rtl/owd_win_regs.sv
module owd_win_regs
  import owd_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_win,
  input  logic                     cfg_en,
  input  logic [DEC_W-1:0]         cfg_base,
  input  logic [DEC_W-1:0]         cfg_mask,
  input  logic [DEC_W-1:0]         cfg_trans,
  output win_cfg_t [NUM_WIN-1:0]   cfg_q
);
  // One storage slot per window; an index with no slot writes nothing.
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (cfg_we && cfg_win == IDX_W'(g)) begin
        cfg_q[g].en    <= cfg_en;
        cfg_q[g].base  <= cfg_base;
        cfg_q[g].mask  <= cfg_mask;
        cfg_q[g].trans <= cfg_trans;
      end
    end
  end
endmodule

// File: rtl/owd_win_match.sv
module owd_win_match
  import owd_pkg::*;
(
  input  win_cfg_t         cfg,
  input  logic [DEC_W-1:0] top_in,
  output logic             hit,
  output logic [DEC_W-1:0] top_out
);
  logic [DEC_W-1:0] keep;

  always_comb begin
    keep    = ~cfg.mask;
    hit     = cfg.en && ((top_in & keep) == (cfg.base & keep));
    top_out = (cfg.trans & keep) | (top_in & cfg.mask);
  end
endmodule

// File: rtl/owd_prio_sel.sv
module owd_prio_sel
  import owd_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_WIN-1:0]            hit_vec,
  input  logic [NUM_WIN-1:0][DEC_W-1:0] top_vec,
  output logic                          any_hit,
  output logic [IDX_W-1:0]              win_idx,
  output logic [DEC_W-1:0]              win_top
);
  // Walk from the highest index down so the lowest matching index is kept.
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    win_top = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
        win_top = top_vec[i];
      end
    end
  end
endmodule

// File: rtl/owd_decoder.sv
module owd_decoder
  import owd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_win,
  input  logic              cfg_en,
  input  logic [DEC_W-1:0]  cfg_base,
  input  logic [DEC_W-1:0]  cfg_mask,
  input  logic [DEC_W-1:0]  cfg_trans,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_idx,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int LOW_W = ADDR_W - DEC_W;

  win_cfg_t [NUM_WIN-1:0]            cfg_q;
  logic     [NUM_WIN-1:0]            hit_vec;
  logic     [NUM_WIN-1:0][DEC_W-1:0] top_vec;
  logic                              any_hit;
  logic     [IDX_W-1:0]              win_idx;
  logic     [DEC_W-1:0]              win_top;
  logic                              accept;

  owd_win_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_win  (cfg_win),
    .cfg_en   (cfg_en),
    .cfg_base (cfg_base),
    .cfg_mask (cfg_mask),
    .cfg_trans(cfg_trans),
    .cfg_q    (cfg_q)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
    owd_win_match u_match (
      .cfg    (cfg_q[g]),
      .top_in (in_addr[ADDR_W-1:LOW_W]),
      .hit    (hit_vec[g]),
      .top_out(top_vec[g])
    );
  end

  owd_prio_sel #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_prio (
    .hit_vec(hit_vec),
    .top_vec(top_vec),
    .any_hit(any_hit),
    .win_idx(win_idx),
    .win_top(win_top)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_idx   <= '0;
      out_addr  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_hit   <= any_hit;
      out_idx   <= any_hit ? win_idx : '0;
      out_addr  <= any_hit ? {win_top, in_addr[LOW_W-1:0]} : in_addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/owd_chk.sv
module owd_chk #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = 2,
  parameter int LOW_W   = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hit,
  input logic [IDX_W-1:0]  out_idx,
  input logic [ADDR_W-1:0] out_addr
);
  // R7
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_hit) && $stable(out_idx)));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  miss_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_idx == '0));

  // R6
  miss_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_hit || out_addr == $past(in_addr)));

  // R5
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_addr[LOW_W-1:0] == $past(in_addr[LOW_W-1:0])));

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_idx) < NUM_WIN));
endmodule

bind owd_decoder owd_chk #(
  .ADDR_W (ADDR_W),
  .NUM_WIN(NUM_WIN),
  .IDX_W  (IDX_W),
  .LOW_W  (LOW_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_addr  (in_addr),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_hit  (out_hit),
  .out_idx  (out_idx),
  .out_addr (out_addr)
);

// File: tb/tb_owd_decoder.sv
`timescale 1ns/100ps
module tb_owd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_win = '0;
  logic        cfg_en = 1'b0;
  logic [7:0]  cfg_base = '0, cfg_mask = '0, cfg_trans = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_hit;
  logic [1:0]  out_idx;
  logic [31:0] out_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  owd_decoder dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_en(cfg_en),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_trans(cfg_trans),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_idx(out_idx), .out_addr(out_addr)
  );

  // Behavioural reference model
  logic [7:0]  m_base [3];
  logic [7:0]  m_mask [3];
  logic [7:0]  m_trans[3];
  logic        m_en   [3];
  logic        m_valid, m_hit;
  logic [1:0]  m_idx;
  logic [31:0] m_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0; m_hit <= 1'b0; m_idx <= '0; m_addr <= '0;
      for (int k = 0; k < 3; k++) begin
        m_en[k] <= 1'b0; m_base[k] <= '0; m_mask[k] <= '0; m_trans[k] <= '0;
      end
    end else begin
      if (in_valid && (!m_valid || out_ready)) begin
        bit found;
        found = 1'b0;
        m_valid <= 1'b1;
        m_hit   <= 1'b0;
        m_idx   <= '0;
        m_addr  <= in_addr;
        for (int k = 0; k < 3; k++) begin
          if (!found && m_en[k] &&
              ((in_addr[31:24] & ~m_mask[k]) == (m_base[k] & ~m_mask[k]))) begin
            found  = 1'b1;
            m_hit  <= 1'b1;
            m_idx  <= 2'(k);
            m_addr <= {(m_trans[k] & ~m_mask[k]) | (in_addr[31:24] & m_mask[k]), in_addr[23:0]};
          end
        end
      end else if (out_ready) begin
        m_valid <= 1'b0;
      end
      if (cfg_we && cfg_win != 2'd3) begin
        m_en[cfg_win]    <= cfg_en;
        m_base[cfg_win]  <= cfg_base;
        m_mask[cfg_win]  <= cfg_mask;
        m_trans[cfg_win] <= cfg_trans;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // Cycle compare against the model, 1 ns after each edge
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !done) begin
      chk("R7", "model out_valid", 32'(out_valid), 32'(m_valid));
      chk("R8", "model in_ready", 32'(in_ready), 32'(!m_valid || out_ready));
      if (m_valid) begin
        chk("R2", "model out_hit", 32'(out_hit), 32'(m_hit));
        chk("R4", "model out_idx", 32'(out_idx), 32'(m_idx));
        chk("R5", "model out_addr", out_addr, m_addr);
      end
    end
  end

  task automatic wr(input logic [1:0] w, input logic en, input logic [7:0] b, input logic [7:0] m, input logic [7:0] t);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = w; cfg_en = en; cfg_base = b; cfg_mask = m; cfg_trans = t;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic txn(input string tag, input logic [31:0] a, input logic hit, input logic [1:0] idx, input logic [31:0] exp_a);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "valid", 32'(out_valid), 32'd1);
    chk(tag, "hit", 32'(out_hit), 32'(hit));
    chk(tag, "idx", 32'(out_idx), 32'(idx));
    chk(tag, "addr", out_addr, exp_a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty stage and all windows off
    chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1", "in_ready after reset", 32'(in_ready), 32'd1);
    txn("R1", 32'h4012_3456, 1'b0, 2'd0, 32'h4012_3456);

    // R2/R5: exact 16 MB window
    wr(2'd2, 1'b1, 8'h40, 8'h00, 8'h80);
    txn("R2", 32'h4012_3456, 1'b1, 2'd2, 32'h8012_3456);
    txn("R2", 32'h4112_3456, 1'b0, 2'd0, 32'h4112_3456);

    // R5: larger masked window passes masked bits through
    wr(2'd1, 1'b1, 8'h40, 8'h3F, 8'hC0);
    txn("R5", 32'h7F00_0001, 1'b1, 2'd1, 32'hFF00_0001);
    // R4: windows 1 and 2 both match, 1 wins
    txn("R4", 32'h40AB_CDEF, 1'b1, 2'd1, 32'hC0AB_CDEF);

    // R3: disabled window 0 on the same range is ignored
    wr(2'd0, 1'b0, 8'h40, 8'h00, 8'h11);
    txn("R3", 32'h40AB_CDEF, 1'b1, 2'd1, 32'hC0AB_CDEF);
    // R4: enabling window 0 makes it win
    wr(2'd0, 1'b1, 8'h40, 8'h00, 8'h11);
    txn("R4", 32'h40AB_CDEF, 1'b1, 2'd0, 32'h11AB_CDEF);

    // R6: miss leaves address and zero index
    txn("R6", 32'h2000_0010, 1'b0, 2'd0, 32'h2000_0010);

    // R10: write to index 3 changes nothing
    wr(2'd3, 1'b1, 8'h20, 8'h00, 8'h99);
    txn("R10", 32'h2000_0010, 1'b0, 2'd0, 32'h2000_0010);

    // R9: write and request on the same edge use old settings
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 2'd2; cfg_en = 1'b1; cfg_base = 8'h30; cfg_mask = 8'h00; cfg_trans = 8'h05;
    in_valid = 1'b1; in_addr = 32'h3000_0044;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R9", "same-edge hit", 32'(out_hit), 32'd0);
    txn("R9", 32'h3000_0044, 1'b1, 2'd2, 32'h0500_0044);

    // R8: back-pressure holds the result and refuses input
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = 32'h3012_0000;
    @(negedge clk);
    in_addr = 32'h2000_0001;
    for (int c = 0; c < 3; c++) begin
      chk("R8", "held addr", out_addr, 32'h0512_0000);
      chk("R8", "in_ready low", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "next result", out_addr, 32'h2000_0001);
    chk("R7", "next valid", 32'(out_valid), 32'd1);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      in_valid  = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 3) != 0);
      in_addr   = {8'($urandom_range(0, 7) << 4) | 8'($urandom_range(0, 1)), 24'($urandom)};
      cfg_we    = ($urandom_range(0, 15) == 0);
      cfg_win   = 2'($urandom_range(0, 3));
      cfg_en    = 1'($urandom);
      cfg_base  = 8'($urandom_range(0, 7) << 4);
      cfg_mask  = 8'($urandom_range(0, 3) == 0 ? 8'h3F : 8'h00);
      cfg_trans = 8'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule